// File: doc/BRIEF.md
# Core-Driven Parallel Port Transfer Controller

This block lets a processor core move 32-bit words between itself and a simple strobe-based external memory bus without DMA. The core programs a starting external byte address, a signed address step, a transfer count and a control word through a small register interface. It then either writes words into a transmit holding register, each of which becomes one external write cycle, or reads words out of a two-entry receive buffer that the block keeps filled by fetching from external memory on its own.

Every external cycle holds its read or write strobe for a programmable number of clocks, then drops it for at least one clock. After each cycle the address moves by the signed step and the count drops by one. The address, step and count registers are locked while the port is enabled, so the core reprograms them only between runs. This suits access patterns such as stepping backwards through a delay line.

Register offsets on `reg_addr`: 0 control, 1 external address, 2 address step, 3 count, 4 transmit data (write), 5 receive data (read), 6 status (read).

Top module: `ppx_core_port`

## Requirements
- R1: The control register (offset 0) holds the enable in bit 0, the direction in bit 1 (1 = transmit, 0 = receive), the DMA-enable in bit 2 and the strobe duration in bits [7:4]. One write sets all fields at once, and a read returns them. Reset clears control and status to 0, and both strobes are low.
- R2: Writes to the address (1), step (2) and count (3) registers take effect only while the enable is 0 and no cycle is in progress. Otherwise they are ignored, and read-back shows the old values.
- R3: In receive mode, after the write that sets the enable, the read strobe is low for the next two clock edges and rises at the second. Two words are then fetched with no further core action.
- R4: In transmit mode no external cycle starts until the core writes offset 4. Each accepted word produces one write cycle that drives that word and the current address.
- R5: After each external cycle the address register advances by the signed step, with 32-bit wrap-around. It reads back at offset 1.
- R6: The count register decrements by one per external cycle and wraps from 0 to all ones. Its value never stops transfers.
- R7: The strobe stays high for the number of clocks in the duration field (0 acts as 1) and is then low for at least one clock. Back-to-back receive fetches are separated by exactly one low clock.
- R8: The receive buffer holds two words in arrival order. Status bits [2:1] give its fill level. Popping a word (a read of offset 5) frees a slot and a new fetch follows. A read of offset 5 while the buffer is empty returns 0 and changes nothing.
- R9: Transmit data passes through one holding register, and status bit 0 is 1 while it is full. A write to offset 4 while it is full is ignored.
- R10: Clearing the enable lets a cycle already in progress run to full length, starts no new cycle and empties the receive buffer (fill level 0).
- R11: While the DMA-enable bit is 1 the block starts no external cycle.
- R12: The read and write strobes are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops receive data at offset 5) |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data, combinational from `reg_addr` |
| ext_addr | output | AW | External byte address |
| ext_wdata | output | DW | External write data |
| ext_rdata | input | DW | External read data, sampled on the last strobe clock |
| ext_rd | output | 1 | External read strobe |
| ext_wr | output | 1 | External write strobe |

## Verification
The assertions check on every cycle that the two strobes never overlap, that the parameter registers hold still while enabled, that the buffer level stays within two entries, that the count steps down by one per cycle, and that a write strobe only runs with a full holding register. They also check that a new cycle starts only after the enable has settled and only with DMA-enable clear. The bench scenarios are needed for the rest: the exact rise of the first fetch after enable, the strobe widths and the one-clock gap, the address sequence for positive, negative and zero steps, and the data order out of the buffer. The same holds for the dropped second transmit write, the completion of a cycle cut off by disable, and the buffer flush.

// File: rtl/ppx_core_port.sv
module ppx_core_port #(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int DURW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [2:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic [AW-1:0] ext_addr,
  output logic [DW-1:0] ext_wdata,
  input  logic [DW-1:0] ext_rdata,
  output logic          ext_rd,
  output logic          ext_wr
);

  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_ADDR = 3'd1;
  localparam logic [2:0] A_STEP = 3'd2;
  localparam logic [2:0] A_CNT  = 3'd3;
  localparam logic [2:0] A_TX   = 3'd4;
  localparam logic [2:0] A_RX   = 3'd5;
  localparam logic [2:0] A_STAT = 3'd6;
  localparam int         DLSB   = 4;

  typedef enum logic [1:0] {S_IDLE, S_ACT, S_GAP} st_t;

  st_t             st;
  logic            en_q, dir_q, dma_q, en_p1, cur_tx;
  logic [DURW-1:0] dur_q, dcnt;
  logic [AW-1:0]   xaddr, xstep;
  logic [DW-1:0]   xcnt, tx_hold;
  logic            tx_full;
  logic [DW-1:0]   rx_mem [2];
  logic            wp, rp;
  logic [1:0]      lvl;

  wire wr_ctrl = reg_wr && reg_addr == A_CTRL;
  wire par_ok  = !en_q && st != S_ACT;
  wire go_rx   = en_q && en_p1 && !dir_q && !dma_q && lvl < 2'd2;
  wire go_tx   = en_q && dir_q && !dma_q && tx_full;
  wire go      = go_rx || go_tx;
  wire xend    = st == S_ACT && dcnt == '0;
  wire push    = xend && !cur_tx && en_q;
  wire pop     = reg_rd && reg_addr == A_RX && lvl != 2'd0;
  wire [DURW-1:0] dlen = (dur_q == '0) ? '0 : dur_q - 1'b1;

  assign ext_rd    = st == S_ACT && !cur_tx;
  assign ext_wr    = st == S_ACT && cur_tx;
  assign ext_addr  = xaddr;
  assign ext_wdata = tx_hold;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= 1'b0; dir_q <= 1'b0; dma_q <= 1'b0; dur_q <= '0; en_p1 <= 1'b0;
    end else begin
      en_p1 <= en_q;
      if (wr_ctrl) begin
        en_q  <= reg_wdata[0];
        dir_q <= reg_wdata[1];
        dma_q <= reg_wdata[2];
        dur_q <= reg_wdata[DLSB +: DURW];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; dcnt <= '0; cur_tx <= 1'b0;
    end else begin
      case (st)
        S_ACT: begin
          if (dcnt == '0) st <= S_GAP;
          else dcnt <= dcnt - 1'b1;
        end
        default: begin
          if (go) begin
            st     <= S_ACT;
            dcnt   <= dlen;
            cur_tx <= go_tx;
          end else begin
            st <= S_IDLE;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      xaddr <= '0; xstep <= '0; xcnt <= '0;
    end else if (xend) begin
      xaddr <= xaddr + xstep;
      xcnt  <= xcnt - DW'(1);
    end else if (reg_wr && par_ok) begin
      case (reg_addr)
        A_ADDR:  xaddr <= reg_wdata[AW-1:0];
        A_STEP:  xstep <= reg_wdata[AW-1:0];
        A_CNT:   xcnt  <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_hold <= '0; tx_full <= 1'b0;
    end else if (reg_wr && reg_addr == A_TX && !tx_full) begin
      tx_hold <= reg_wdata;
      tx_full <= 1'b1;
    end else if (xend && cur_tx) begin
      tx_full <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= 1'b0; rp <= 1'b0; lvl <= 2'd0;
      rx_mem[0] <= '0; rx_mem[1] <= '0;
    end else if (!en_q) begin
      wp <= 1'b0; rp <= 1'b0; lvl <= 2'd0;
    end else begin
      if (push) begin
        rx_mem[wp] <= ext_rdata;
        wp <= ~wp;
      end
      if (pop) rp <= ~rp;
      lvl <= lvl + {1'b0, push} - {1'b0, pop};
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL: begin
        reg_rdata[0] = en_q;
        reg_rdata[1] = dir_q;
        reg_rdata[2] = dma_q;
        reg_rdata[DLSB +: DURW] = dur_q;
      end
      A_ADDR:  reg_rdata = DW'(xaddr);
      A_STEP:  reg_rdata = DW'(xstep);
      A_CNT:   reg_rdata = xcnt;
      A_RX:    reg_rdata = (lvl == 2'd0) ? '0 : rx_mem[rp];
      A_STAT:  reg_rdata[3:0] = {st == S_ACT, lvl, tx_full};
      default: reg_rdata = '0;
    endcase
  end

  assert_one_strobe_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(ext_rd && ext_wr));

  assert_params_locked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |=> $stable(xstep));

  assert_rx_depth_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lvl <= 2'd2);

  assert_count_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    xend |=> xcnt == $past(xcnt) - DW'(1));

  assert_wr_has_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ext_wr |-> tx_full);

  assert_start_gated_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_rd || ext_wr) |-> $past(en_q) && !$past(dma_q));

  assert_rx_settled_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_rd) |-> $past(en_p1) && !$past(dir_q));

endmodule

// File: tb/sim_ppx_core_port.sv
module sim_ppx_core_port;
  localparam int PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [31:0] ext_addr, ext_wdata, ext_rdata;
  logic        ext_rd, ext_wr;

  int n_chk = 0, n_bad = 0;
  int hi_n = 0, lo_n = 0, min_gap = 999, acc_n = 0, last_w = 0;
  bit have_prev = 0, last_wr = 0;
  logic [31:0] cur_a, cur_d, last_a, last_d;
  bit cur_wr;

  ppx_core_port u0 (.clk, .rst_n, .reg_wr, .reg_rd, .reg_addr, .reg_wdata,
    .reg_rdata, .ext_addr, .ext_wdata, .ext_rdata, .ext_rd, .ext_wr);

  always #(PERIOD/2) clk = ~clk;

  function automatic logic [31:0] mdat(logic [31:0] x);
    return {x[15:0], ~x[15:0]};
  endfunction
  assign ext_rdata = mdat(ext_addr);

  always @(negedge clk) begin
    if (ext_rd || ext_wr) begin
      if (hi_n == 0 && have_prev && lo_n < min_gap) min_gap = lo_n;
      hi_n++; lo_n = 0;
      cur_a = ext_addr; cur_d = ext_wdata; cur_wr = ext_wr;
    end else begin
      if (hi_n > 0) begin
        last_w = hi_n; last_a = cur_a; last_d = cur_d; last_wr = cur_wr;
        acc_n++; have_prev = 1; hi_n = 0;
      end
      lo_n++;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic pop(output logic [31:0] d);
    @(negedge clk); reg_addr = 3'd5; reg_rd = 1'b1; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic peek(logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  // {addr, step, count, duration, pops}
  localparam logic [103:0] VEC [0:4] = '{
    {32'h0000_0100, 32'h0000_0004, 32'd10,  4'd1,  4'd3},
    {32'h0000_2000, 32'hFFFF_FFF8, 32'd0,   4'd0,  4'd2},
    {32'h0000_0040, 32'h0000_0010, 32'd5,   4'd15, 4'd1},
    {32'hFFFF_FFF0, 32'h0000_0020, 32'd100, 4'd3,  4'd4},
    {32'h0000_0008, 32'h0000_0000, 32'd1,   4'd2,  4'd2}
  };

  initial begin
    #(PERIOD * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int a0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state, R12
    @(negedge clk);
    chk("R12 rd strobe at reset", {31'd0, ext_rd}, 32'd0);
    chk("R12 wr strobe at reset", {31'd0, ext_wr}, 32'd0);
    peek(3'd0, d); chk("R1 ctrl after reset", d, 32'd0);
    peek(3'd6, d); chk("R1 status after reset", d, 32'd0);

    // vector table: receive runs (R3 R5 R6 R7 R8)
    for (int i = 0; i < 5; i++) begin
      logic [31:0] va, vm, vc, eff;
      logic [3:0]  vd, vn;
      {va, vm, vc, vd, vn} = VEC[i];
      eff = (vd == 0) ? 32'd1 : 32'(vd);
      wr(3'd0, 32'd0);
      repeat (20) @(negedge clk);
      wr(3'd1, va); wr(3'd2, vm); wr(3'd3, vc);
      have_prev = 0; min_gap = 999;
      wr(3'd0, {24'd0, vd, 4'b0001});
      chk("R3 no fetch at first edge", {31'd0, ext_rd}, 32'd0);
      @(negedge clk);
      chk("R3 no fetch at second edge", {31'd0, ext_rd}, 32'd0);
      @(negedge clk);
      chk("R3 fetch begins", {31'd0, ext_rd}, 32'd1);
      repeat (60) @(negedge clk);
      peek(3'd6, d); chk("R8 buffer full after prefetch", {30'd0, d[2:1]}, 32'd2);
      for (int j = 0; j < int'(vn); j++) begin
        pop(d);
        chk("R8 data order", d, mdat(va + vm * j));
        repeat (40) @(negedge clk);
      end
      peek(3'd1, d); chk("R5 address after run", d, va + vm * (vn + 2));
      peek(3'd3, d); chk("R6 count after run", d, vc - 32'(vn) - 32'd2);
      chk("R7 strobe width", last_w, eff);
      chk("R7 gap between fetches", min_gap, 32'd1);
    end

    // R1 readback, R11 DMA-enable blocks
    wr(3'd0, 32'd0);
    repeat (20) @(negedge clk);
    wr(3'd0, 32'h0000_00A6);
    peek(3'd0, d); chk("R1 ctrl readback", d, 32'h0000_00A6);
    a0 = acc_n;
    wr(3'd0, 32'h0000_00A5);
    repeat (20) @(negedge clk);
    chk("R11 no cycle with dma bit", acc_n, a0);
    peek(3'd6, d); chk("R11 buffer stays empty", d, 32'd0);

    // R2 lock while enabled
    wr(3'd0, 32'd0);
    wr(3'd1, 32'h500); wr(3'd2, 32'd4); wr(3'd3, 32'd7);
    wr(3'd0, 32'h0000_0013);
    wr(3'd1, 32'h999); wr(3'd2, 32'h77); wr(3'd3, 32'd0);
    peek(3'd1, d); chk("R2 address locked", d, 32'h500);
    peek(3'd2, d); chk("R2 step locked", d, 32'd4);
    peek(3'd3, d); chk("R2 count locked", d, 32'd7);

    // R4 transmit waits for data, R9 full flag
    a0 = acc_n;
    repeat (10) @(negedge clk);
    chk("R4 idle without data", acc_n, a0);
    wr(3'd4, 32'hCAFE_0001);
    peek(3'd6, d); chk("R9 holding full", {31'd0, d[0]}, 32'd1);
    repeat (10) @(negedge clk);
    chk("R4 one write cycle", acc_n, a0 + 1);
    chk("R4 write address", last_a, 32'h500);
    chk("R4 write data", last_d, 32'hCAFE_0001);
    chk("R4 write strobe used", {31'd0, last_wr}, 32'd1);
    peek(3'd6, d); chk("R9 holding cleared", {31'd0, d[0]}, 32'd0);
    peek(3'd1, d); chk("R5 address after write", d, 32'h504);

    // R9 write while full dropped
    wr(3'd0, 32'd0);
    wr(3'd0, 32'h0000_00F3);
    a0 = acc_n;
    wr(3'd4, 32'h1111_1111);
    wr(3'd4, 32'h2222_2222);
    repeat (50) @(negedge clk);
    chk("R9 second word dropped", acc_n, a0 + 1);
    chk("R9 first word kept", last_d, 32'h1111_1111);
    chk("R7 long strobe", last_w, 32'd15);

    // R10 disable mid-cycle
    wr(3'd0, 32'd0);
    wr(3'd1, 32'h0); wr(3'd2, 32'd4);
    a0 = acc_n;
    wr(3'd0, 32'h0000_00A1);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (ext_rd) break;
    end
    repeat (3) @(negedge clk);
    wr(3'd0, 32'd0);
    repeat (30) @(negedge clk);
    chk("R10 cut cycle runs full", last_w, 32'd10);
    chk("R10 no new cycle", acc_n, a0 + 1);
    peek(3'd6, d); chk("R10 buffer flushed", d, 32'd0);
    pop(d); chk("R8 empty read is zero", d, 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule